// File: doc/BRIEF.md
# Blocked-Access Responder for a Block-Based Memory Protection Controller

This block answers every bus transaction that a block-based memory protection controller has already refused. Each refused request arrives with its address, its direction, a secure/non-secure attribute and a 16-bit requester identifier. The block also receives a bit-per-block security lookup table from its surroundings. One cycle after it accepts a request, it returns a response. The response never carries read data and never changes memory. A control bit decides whether that response is a bus error or a quiet read-as-zero/write-ignored completion.

The first refused access after software has acknowledged the last one is recorded in two capture registers. One holds the full address. The other holds the requester identifier, the inverted secure attribute and the lookup-table bit that covers the address. The capture raises a status flag, and the flag drives an interrupt through an enable bit. Later refused accesses are still answered, but they do not touch the capture registers until software clears the flag.

A small word-addressed register port gives access to the control bit, the status, the enable, set and clear strobes, and both capture registers.

Top module: `mpc_block_responder`

## Requirements
- R1: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. Exactly one cycle later, `rsp_valid` is high for one cycle and `rsp_rdata` is all zeros, for reads and for writes alike.
- R2: For an address inside the table, `rsp_err` equals bit 0 of the control register (offset 0x00) as it stood when the request was accepted. A value of 1 gives a bus error; a value of 0 gives an OK completion.
- R3: An address whose block number is at or above `LUT_WORDS*32` is out of range. It is always answered with `rsp_err`=1, and its captured table bit reads 0.
- R4: An accepted request while the status flag (offset 0x20, bit 0) is clear loads the zero-extended address into capture register A (offset 0x2C) and sets the status flag.
- R5: The same capture loads capture register B (offset 0x30) as follows: bits [15:0] hold the requester ID, bit 16 holds the inverse of `req_secure`, bit 17 holds the table bit, and bits [31:18] are zero.
- R6: The table bit for an address is found from its block number, which is the address shifted right by `BLK_SHIFT`. The word index is the block number divided by 32, and the bit index is the block number modulo 32. With the flat vector used here, this is `lut_bits[block]`.
- R7: While the status flag is set, further requests are still answered but leave both capture registers unchanged.
- R8: `irq` is high exactly when the status flag and the enable bit (offset 0x28, bit 0) are both set.
- R9: Writing 1 to bit 0 at offset 0x24 clears the status flag and re-arms capture. Writing 1 to bit 0 at offset 0x34 sets the status flag without changing the capture registers.
- R10: In a cycle with a clear write, `req_ready` is low, so the clear takes effect and no request is accepted. A request still held on the next cycle is accepted and captured.
- R11: After reset, `rsp_valid`, `irq` and all registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Refused request present |
| req_ready | output | 1 | Request may be accepted this cycle |
| req_addr | input | ADDR_W | Request address within the protected region |
| req_write | input | 1 | 1 for write, 0 for read |
| req_secure | input | 1 | Secure attribute of the request |
| req_id | input | 16 | Requester identifier |
| lut_bits | input | LUT_WORDS*32 | Security table, one bit per block |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | 1 for bus error, 0 for OK |
| rsp_rdata | output | 32 | Read data, always zero |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt output |

## Verification
The collision case is a status clear written on the same edge at which a refused request is offered. The bench first sets the flag through the set register, then drives the clear write and a request together. It checks three things: `req_ready` is low in that cycle, no response follows it, and the held request is accepted, answered and captured on the next cycle. The capture register must then hold that request's address, with the flag set again.

// File: rtl/mpc_block_responder.sv
module mpc_block_responder #(
  parameter int ADDR_W    = 20,
  parameter int BLK_SHIFT = 8,
  parameter int LUT_WORDS = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic                    req_write,
  input  logic                    req_secure,
  input  logic [15:0]             req_id,
  input  logic [LUT_WORDS*32-1:0] lut_bits,
  output logic                    rsp_valid,
  output logic                    rsp_err,
  output logic [31:0]             rsp_rdata,
  input  logic                    reg_wr,
  input  logic [7:0]              reg_addr,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  output logic                    irq
);
  localparam int NBLK  = LUT_WORDS * 32;
  localparam int BLK_W = ADDR_W - BLK_SHIFT;
  localparam int IDX_W = $clog2(NBLK);
  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_STAT  = 8'h20;
  localparam logic [7:0] OFS_CLR   = 8'h24;
  localparam logic [7:0] OFS_EN    = 8'h28;
  localparam logic [7:0] OFS_INFOA = 8'h2C;
  localparam logic [7:0] OFS_INFOB = 8'h30;
  localparam logic [7:0] OFS_SET   = 8'h34;

  logic        err_mode_q, en_q, stat_q;
  logic [31:0] info1_q, info2_q;

  wire clr_hit = reg_wr && (reg_addr == OFS_CLR) && reg_wdata[0];
  wire set_hit = reg_wr && (reg_addr == OFS_SET) && reg_wdata[0];

  assign req_ready = !clr_hit;
  wire accept  = req_valid && req_ready;
  wire capture = accept && !stat_q;

  wire [BLK_W-1:0] blk = req_addr[ADDR_W-1:BLK_SHIFT];
  wire in_range = blk < BLK_W'(NBLK);
  wire lut_bit  = in_range ? lut_bits[blk[IDX_W-1:0]] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= accept;
      rsp_err   <= accept && (err_mode_q || !in_range);
    end
  end

  assign rsp_rdata = '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_mode_q <= 1'b0;
      en_q       <= 1'b0;
    end else if (reg_wr) begin
      if (reg_addr == OFS_CTRL) err_mode_q <= reg_wdata[0];
      if (reg_addr == OFS_EN)   en_q       <= reg_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  stat_q <= 1'b0;
    else if (clr_hit)            stat_q <= 1'b0;
    else if (capture || set_hit) stat_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      info1_q <= '0;
      info2_q <= '0;
    end else if (capture) begin
      info1_q <= 32'(req_addr);
      info2_q <= {14'd0, lut_bit, ~req_secure, req_id};
    end
  end

  assign irq = stat_q & en_q;

  always_comb begin
    case (reg_addr)
      OFS_CTRL:  reg_rdata = {31'd0, err_mode_q};
      OFS_STAT:  reg_rdata = {31'd0, stat_q};
      OFS_EN:    reg_rdata = {31'd0, en_q};
      OFS_INFOA: reg_rdata = info1_q;
      OFS_INFOB: reg_rdata = info2_q;
      default:   reg_rdata = '0;
    endcase
  end

  wire unused_ok = req_write;
endmodule

module mpc_block_responder_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_valid,
  input logic rsp_err,
  input logic irq,
  input logic stat_q,
  input logic err_mode_q,
  input logic in_range,
  input logic clr_hit,
  input logic [31:0] info1_q,
  input logic [31:0] info2_q
);
  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid); // R1
  AST_ERR_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && err_mode_q) |=> rsp_err); // R2
  AST_OOR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !in_range) |=> rsp_err); // R3
  AST_CAPTURE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> stat_q); // R4
  AST_INFO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q |=> ($stable(info1_q) && $stable(info2_q))); // R7
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> stat_q); // R8
  AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> !stat_q); // R9
  AST_CLEAR_BLOCKS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && clr_hit) |=> !rsp_valid); // R10
endmodule

bind mpc_block_responder mpc_block_responder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .irq(irq), .stat_q(stat_q),
  .err_mode_q(err_mode_q), .in_range(in_range), .clr_hit(clr_hit),
  .info1_q(info1_q), .info2_q(info2_q)
);

// File: tb/tb_mpc_block_responder.sv
module tb_mpc_block_responder;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 20;
  localparam int NBLK = 64;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_secure = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [15:0] req_id = '0;
  logic [NBLK-1:0] lut_bits = 64'hA5A5_0F0F_1234_8001;
  logic req_ready, rsp_valid, rsp_err, irq;
  logic [31:0] rsp_rdata, reg_rdata;
  logic reg_wr = 0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  int n_checks = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mpc_block_responder dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_secure(req_secure),
    .req_id(req_id), .lut_bits(lut_bits), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_info2(input logic [ADDR_W-1:0] a, input logic s,
                                            input logic [15:0] id);
    int b = int'(a >> 8);
    logic lb = (b < NBLK) ? lut_bits[b] : 1'b0;
    return {14'd0, lb, ~s, id};
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic acc(input logic [ADDR_W-1:0] a, input logic w, input logic s,
                     input logic [15:0] id, output logic v, output logic e,
                     output logic [31:0] dat);
    @(negedge clk); req_valid = 1; req_addr = a; req_write = w; req_secure = s; req_id = id;
    @(negedge clk); req_valid = 0; v = rsp_valid; e = rsp_err; dat = rsp_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R11 rsp_valid", 32'(rsp_valid), 0);
    chk("R11 irq", 32'(irq), 0);
    foreach (d[i]) if (i < 0) d = 0;
    rd(8'h00, d); chk("R11 ctrl", d, 0);
    rd(8'h20, d); chk("R11 stat", d, 0);
    rd(8'h28, d); chk("R11 en", d, 0);
    rd(8'h2C, d); chk("R11 infoA", d, 0);
    rd(8'h30, d); chk("R11 infoB", d, 0);
  endtask

  task automatic t_ok_read;
    logic v, e; logic [31:0] dat, d;
    acc(20'h00120, 0, 1, 16'hBEEF, v, e, dat);
    chk("R1 rsp_valid", 32'(v), 1);
    chk("R1 rdata", dat, 0);
    chk("R2 ok", 32'(e), 0);
    rd(8'h2C, d); chk("R4 infoA", d, 32'h00120);
    rd(8'h20, d); chk("R4 stat", d, 1);
    rd(8'h30, d); chk("R5 infoB", d, exp_info2(20'h00120, 1, 16'hBEEF));
    chk("R8 irq off", 32'(irq), 0);
    wr(8'h28, 1);
    chk("R8 irq on", 32'(irq), 1);
    wr(8'h24, 1);
    chk("R9 irq after clear", 32'(irq), 0);
    rd(8'h20, d); chk("R9 stat cleared", d, 0);
  endtask

  task automatic t_err_mode;
    logic v, e; logic [31:0] dat, d;
    wr(8'h00, 1);
    acc(20'h03F00, 1, 0, 16'h0042, v, e, dat);
    chk("R2 err", 32'(e), 1);
    chk("R1 write rdata", dat, 0);
    rd(8'h30, d); chk("R5 nonsec", d, exp_info2(20'h03F00, 0, 16'h0042));
    wr(8'h00, 0);
    wr(8'h24, 1);
  endtask

  task automatic t_first_only;
    logic v, e; logic [31:0] dat, d;
    acc(20'h00410, 0, 0, 16'h1111, v, e, dat);
    acc(20'h00950, 1, 1, 16'h2222, v, e, dat);
    chk("R7 second answered", 32'(v), 1);
    rd(8'h2C, d); chk("R7 infoA held", d, 32'h00410);
    rd(8'h30, d); chk("R7 infoB held", d, exp_info2(20'h00410, 0, 16'h1111));
    wr(8'h24, 1);
    acc(20'h00950, 1, 1, 16'h2222, v, e, dat);
    rd(8'h2C, d); chk("R9 rearmed", d, 32'h00950);
    wr(8'h24, 1);
  endtask

  task automatic t_oor;
    logic v, e; logic [31:0] dat, d;
    acc(20'h80000, 0, 0, 16'h7777, v, e, dat);
    chk("R3 err", 32'(e), 1);
    rd(8'h30, d); chk("R3 lut bit zero", d, {14'd0, 1'b0, 1'b1, 16'h7777});
    wr(8'h24, 1);
    acc(20'h04000, 0, 1, 16'h0001, v, e, dat);
    chk("R3 first oor block", 32'(e), 1);
    wr(8'h24, 1);
    acc(20'h03FFF, 0, 1, 16'h0001, v, e, dat);
    chk("R3 last block ok", 32'(e), 0);
    wr(8'h24, 1);
  endtask

  task automatic t_lut;
    logic v, e; logic [31:0] dat, d;
    lut_bits = 64'h8000_0001_0000_0002;
    for (int b = 0; b < NBLK; b += 7) begin
      logic [ADDR_W-1:0] a = ADDR_W'(b << 8) | 20'h0004;
      acc(a, 0, 1, 16'(b), v, e, dat);
      rd(8'h30, d); chk("R6 lut bit", d, exp_info2(a, 1, 16'(b)));
      wr(8'h24, 1);
    end
    acc(20'h03F00, 0, 1, 16'h0, v, e, dat);
    rd(8'h30, d); chk("R6 top bit", d, {14'd0, 1'b1, 1'b0, 16'h0});
    wr(8'h24, 1);
  endtask

  task automatic t_set;
    logic [31:0] d, keep;
    rd(8'h2C, keep);
    wr(8'h34, 1);
    rd(8'h20, d); chk("R9 set stat", d, 1);
    rd(8'h2C, d); chk("R9 set no capture", d, keep);
    chk("R8 irq via set", 32'(irq), 1);
    wr(8'h28, 0);
    chk("R8 irq masked", 32'(irq), 0);
    wr(8'h24, 1);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    wr(8'h34, 1);
    @(negedge clk);
    reg_wr = 1; reg_addr = 8'h24; reg_wdata = 1;
    req_valid = 1; req_addr = 20'h02A80; req_secure = 0; req_id = 16'h5A5A;
    #1 chk("R10 ready low", 32'(req_ready), 0);
    @(negedge clk);
    reg_wr = 0; reg_wdata = 0;
    chk("R10 no rsp", 32'(rsp_valid), 0);
    #1 chk("R10 ready back", 32'(req_ready), 1);
    @(negedge clk);
    req_valid = 0;
    chk("R10 rsp next", 32'(rsp_valid), 1);
    rd(8'h2C, d); chk("R10 captured", d, 32'h02A80);
    rd(8'h20, d); chk("R10 stat", d, 1);
    wr(8'h24, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_ok_read();
    t_err_mode();
    t_first_only();
    t_oor();
    t_lut();
    t_set();
    t_collide();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule